// File: doc/BRIEF.md
# Four-Channel Shared Bus Multiplexer

This block lets four logical channels share one 64-bit link in each direction. Outbound, a register-access (target) channel and three DMA engine channels compete for a single bus. A round-robin arbiter picks one beat per cycle. The beat is registered onto the bus together with a one-hot channel tag, a pair of per-dword valid bits and an info field. How the info field is packed depends on which channel sent the beat. The receiver returns one almost-full bit per channel, and a channel whose bit is set is not served.

Inbound, each beat arrives with a channel tag, a two-bit start/end marker and three info bits. The block forwards the beat, registered, to exactly the channel named by the tag. A beat whose tag is not one-hot is discarded and sets an error flag that stays set.

Channel index order is fixed throughout. Index 0 is the target channel, and indices 1, 2 and 3 are DMA engines 0, 1 and 2. This order applies to the tag, the almost-full vector and the inbound valid vector.

Top module: `bmx_top`

## Requirements
- R1: While reset is asserted and afterwards, `tx_type`, `tx_dwv`, `ch_vld` and `rx_bad_type` are zero. In any cycle that follows an edge where no beat was taken, `tx_type` and `tx_dwv` are zero.
- R2: A beat taken at a clock edge appears on `tx_data`/`tx_type`/`tx_dwv`/`tx_info` right after that edge. A channel is taken when its ready output is high before the edge. `tx_type` is one-hot, with bit 0 for target and bits 1..3 for DMA engines 0..2. When no packet is in progress, the grant goes to the first eligible channel after the one that last completed a packet, in rising index order with wrap. After reset the search starts at index 0.
- R3: A target beat is always a complete packet. Its `tx_dwv` is 2'b11 when `tg_wide` is set and 2'b01 otherwise. Its `tx_info` carries `tg_wide` in bit 0 and `tg_tag` in bits 4:1.
- R4: A DMA beat copies that engine's dword enables to `tx_dwv`, with bit 0 for the low dword. Its `tx_info` holds bit 0 low dword valid, bit 1 high dword valid, bit 2 demand mode, bit 3 end of frame, and bit 4 zero.
- R5: A DMA beat sent with end of frame low locks the grant to that engine. No other channel is served until that engine sends a beat with end of frame high.
- R6: A requesting channel whose `tx_afull` bit is set is skipped by the arbiter. At most one ready output is high in any cycle.
- R7: If the locked owner's almost-full bit is set, no beat is sent that cycle and no other channel is served.
- R8: A valid inbound beat whose `rx_type` is one-hot appears one cycle later on `ch_vld`, equal to `rx_type`. In that same cycle `ch_data`, `ch_mark` and `ch_info` carry the beat's data, marker and info.
- R9: A valid inbound beat whose `rx_type` is not one-hot (including zero) leaves `ch_vld` zero. It sets `rx_bad_type`, which stays set until reset while later good beats keep routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tg_vld | input | 1 | Target channel has a beat |
| tg_data | input | 64 | Target beat data |
| tg_wide | input | 1 | Target access is 64-bit |
| tg_tag | input | 4 | Target return tag |
| tg_rdy | output | 1 | Target beat taken at next edge |
| dm_vld | input | 3 | Per DMA engine: beat present |
| dm_data | input | 192 | DMA beat data, engine k at bits 64k+63:64k |
| dm_dwen | input | 6 | DMA dword enables, engine k at bits 2k+1:2k |
| dm_demand | input | 3 | DMA demand-mode flag per engine |
| dm_eof | input | 3 | DMA end-of-frame flag per engine |
| dm_rdy | output | 3 | DMA beat taken at next edge, per engine |
| tx_afull | input | 4 | Receiver almost-full per channel |
| tx_data | output | 64 | Outbound bus data |
| tx_type | output | 4 | Outbound one-hot channel tag |
| tx_dwv | output | 2 | Outbound per-dword valid |
| tx_info | output | 5 | Outbound channel-specific info |
| rx_vld | input | 1 | Inbound beat present |
| rx_type | input | 4 | Inbound channel tag |
| rx_mark | input | 2 | Inbound start/end marker |
| rx_info | input | 3 | Inbound info bits |
| rx_data | input | 64 | Inbound data |
| ch_vld | output | 4 | Routed inbound beat, one bit per channel |
| ch_data | output | 64 | Routed inbound data |
| ch_mark | output | 2 | Routed inbound marker |
| ch_info | output | 3 | Routed inbound info |
| rx_bad_type | output | 1 | Sticky flag for a dropped inbound beat |

## Verification
The hardest situation to reach is a DMA engine that holds the grant in the middle of a packet while its own almost-full bit rises and a different channel is requesting. A wrong design either hands the bus to the competitor or sends a beat into a full receiver. The stimulus gets there in steps. It first lets one engine win alone with end of frame low, which locks it. It then raises the target request and that engine's almost-full bit together. Finally it releases back-pressure with end of frame high to close the packet, so the bench can confirm the target is served only afterwards. The round-robin order is checked from a known pointer position, which the preceding scenarios leave in a state the bench tracks.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

  localparam int TAG_W  = 4;
  localparam int INFO_W = TAG_W + 1;
  localparam int RXI_W  = 3;

  // Target beat info: access width flag low, return tag above it.
  function automatic logic [INFO_W-1:0] tgt_info(input logic wide,
                                                 input logic [TAG_W-1:0] tag);
    return {tag, wide};
  endfunction

  // Target dword valids: always the low dword, the high one for wide access.
  function automatic logic [1:0] tgt_dwv(input logic wide);
    return wide ? 2'b11 : 2'b01;
  endfunction

  // DMA beat info: dword enables, demand flag, end-of-frame flag.
  function automatic logic [INFO_W-1:0] dma_info(input logic [1:0] dwen,
                                                 input logic demand,
                                                 input logic eof);
    logic [INFO_W-1:0] r;
    r      = '0;
    r[1:0] = dwen;
    r[2]   = demand;
    r[3]   = eof;
    return r;
  endfunction

endpackage

// File: rtl/bmx_rr_arb.sv
module bmx_rr_arb #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] blk,
  input  logic [NCH-1:0] last,
  output logic [NCH-1:0] fire,
  output logic [IW-1:0]  sel
);

  logic           locked_q;
  logic [IW-1:0]  owner_q;
  logic [IW-1:0]  ptr_q;
  logic [NCH-1:0] elig;
  logic           pick_found;
  logic [IW-1:0]  pick_idx;
  int             cand;

  assign elig = req & ~blk;

  // Search starts one past the channel that last closed a packet.
  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    cand       = 0;
    for (int o = 1; o <= NCH; o++) begin
      cand = (int'(ptr_q) + o) % NCH;
      if (!pick_found && elig[cand]) begin
        pick_found = 1'b1;
        pick_idx   = IW'(cand);
      end
    end
  end

  always_comb begin
    fire = '0;
    if (locked_q) begin
      if (elig[owner_q]) fire[owner_q] = 1'b1;
    end else if (pick_found) begin
      fire[pick_idx] = 1'b1;
    end
  end

  assign sel = locked_q ? owner_q : pick_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      ptr_q    <= IW'(NCH - 1);
    end else if (|fire) begin
      if (last[sel]) begin
        locked_q <= 1'b0;
        ptr_q    <= sel;
      end else begin
        locked_q <= 1'b1;
        owner_q  <= sel;
      end
    end
  end

endmodule

// File: rtl/bmx_tx_pack.sv
module bmx_tx_pack
  import bmx_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 64,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        fire,
  input  logic [IW-1:0]         sel,
  input  logic [NCH*DW-1:0]     data_flat,
  input  logic [NCH*2-1:0]      dwv_flat,
  input  logic [NCH*INFO_W-1:0] info_flat,
  output logic [DW-1:0]         tx_data,
  output logic [NCH-1:0]        tx_type,
  output logic [1:0]            tx_dwv,
  output logic [INFO_W-1:0]     tx_info
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data <= '0;
      tx_type <= '0;
      tx_dwv  <= '0;
      tx_info <= '0;
    end else if (|fire) begin
      tx_data <= data_flat[sel*DW +: DW];
      tx_type <= fire;
      tx_dwv  <= dwv_flat[sel*2 +: 2];
      tx_info <= info_flat[sel*INFO_W +: INFO_W];
    end else begin
      tx_type <= '0;
      tx_dwv  <= '0;
    end
  end

endmodule

// File: rtl/bmx_rx_route.sv
module bmx_rx_route
  import bmx_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic [NCH-1:0]   rx_type,
  input  logic [1:0]       rx_mark,
  input  logic [RXI_W-1:0] rx_info,
  input  logic [DW-1:0]    rx_data,
  output logic [NCH-1:0]   ch_vld,
  output logic [DW-1:0]    ch_data,
  output logic [1:0]       ch_mark,
  output logic [RXI_W-1:0] ch_info,
  output logic             bad
);

  logic good_beat;
  logic bad_beat;

  assign good_beat = rx_vld && $onehot(rx_type);
  assign bad_beat  = rx_vld && !$onehot(rx_type);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_vld  <= '0;
      ch_data <= '0;
      ch_mark <= '0;
      ch_info <= '0;
      bad     <= 1'b0;
    end else begin
      ch_vld <= good_beat ? rx_type : '0;
      if (good_beat) begin
        ch_data <= rx_data;
        ch_mark <= rx_mark;
        ch_info <= rx_info;
      end
      if (bad_beat) bad <= 1'b1;
    end
  end

endmodule

// File: rtl/bmx_top.sv
module bmx_top
  import bmx_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NDMA = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tg_vld,
  input  logic [DW-1:0]       tg_data,
  input  logic                tg_wide,
  input  logic [TAG_W-1:0]    tg_tag,
  output logic                tg_rdy,
  input  logic [NDMA-1:0]     dm_vld,
  input  logic [NDMA*DW-1:0]  dm_data,
  input  logic [NDMA*2-1:0]   dm_dwen,
  input  logic [NDMA-1:0]     dm_demand,
  input  logic [NDMA-1:0]     dm_eof,
  output logic [NDMA-1:0]     dm_rdy,
  input  logic [NDMA:0]       tx_afull,
  output logic [DW-1:0]       tx_data,
  output logic [NDMA:0]       tx_type,
  output logic [1:0]          tx_dwv,
  output logic [INFO_W-1:0]   tx_info,
  input  logic                rx_vld,
  input  logic [NDMA:0]       rx_type,
  input  logic [1:0]          rx_mark,
  input  logic [RXI_W-1:0]    rx_info,
  input  logic [DW-1:0]       rx_data,
  output logic [NDMA:0]       ch_vld,
  output logic [DW-1:0]       ch_data,
  output logic [1:0]          ch_mark,
  output logic [RXI_W-1:0]    ch_info,
  output logic                rx_bad_type
);

  localparam int NCH = NDMA + 1;
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1;

  // Named internal events, visible to the bound checker.
  logic [NCH-1:0]        req_vec;
  logic [NCH-1:0]        last_vec;
  logic [NCH-1:0]        fire_vec;
  logic [IW-1:0]         sel_idx;
  logic [NCH*DW-1:0]     beat_data;
  logic [NCH*2-1:0]      beat_dwv;
  logic [NCH*INFO_W-1:0] beat_info;

  // Channel 0: target, single-beat packets.
  assign req_vec[0]             = tg_vld;
  assign last_vec[0]            = 1'b1;
  assign beat_data[DW-1:0]      = tg_data;
  assign beat_dwv[1:0]          = tgt_dwv(tg_wide);
  assign beat_info[INFO_W-1:0]  = tgt_info(tg_wide, tg_tag);
  assign tg_rdy                 = fire_vec[0];

  // Channels 1..NDMA: DMA engines.
  for (genvar k = 0; k < NDMA; k++) begin : g_dma
    assign req_vec[k+1]                      = dm_vld[k];
    assign last_vec[k+1]                     = dm_eof[k];
    assign beat_data[(k+1)*DW +: DW]         = dm_data[k*DW +: DW];
    assign beat_dwv[(k+1)*2 +: 2]            = dm_dwen[k*2 +: 2];
    assign beat_info[(k+1)*INFO_W +: INFO_W] =
      dma_info(dm_dwen[k*2 +: 2], dm_demand[k], dm_eof[k]);
    assign dm_rdy[k]                         = fire_vec[k+1];
  end

  bmx_rr_arb #(.NCH(NCH)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req_vec),
    .blk  (tx_afull),
    .last (last_vec),
    .fire (fire_vec),
    .sel  (sel_idx)
  );

  bmx_tx_pack #(.NCH(NCH), .DW(DW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire_vec),
    .sel      (sel_idx),
    .data_flat(beat_data),
    .dwv_flat (beat_dwv),
    .info_flat(beat_info),
    .tx_data  (tx_data),
    .tx_type  (tx_type),
    .tx_dwv   (tx_dwv),
    .tx_info  (tx_info)
  );

  bmx_rx_route #(.NCH(NCH), .DW(DW)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_vld (rx_vld),
    .rx_type(rx_type),
    .rx_mark(rx_mark),
    .rx_info(rx_info),
    .rx_data(rx_data),
    .ch_vld (ch_vld),
    .ch_data(ch_data),
    .ch_mark(ch_mark),
    .ch_info(ch_info),
    .bad    (rx_bad_type)
  );

endmodule

// File: rtl/bmx_chk.sv
module bmx_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] fire,
  input logic [NCH-1:0] afull,
  input logic [NCH-1:0] tx_type,
  input logic [1:0]     tx_dwv,
  input logic [NCH-1:0] ch_vld,
  input logic           rx_vld,
  input logic           bad
);

  // R6
  fire_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));

  // R7
  no_full_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & afull) == '0);

  // R2
  tx_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |=> (tx_type == $past(fire)));

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == '0) |=> (tx_type == '0 && tx_dwv == 2'b00));

  // R3
  dwv_with_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_type != '0) == (tx_dwv != 2'b00));

  // R8
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_vld));

  // R8
  route_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_vld != '0) |-> $past(rx_vld));

  // R9
  bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> bad);

endmodule

bind bmx_top bmx_chk #(.NCH(NCH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .fire   (fire_vec),
  .afull  (tx_afull),
  .tx_type(tx_type),
  .tx_dwv (tx_dwv),
  .ch_vld (ch_vld),
  .rx_vld (rx_vld),
  .bad    (rx_bad_type)
);

// File: tb/bmx_top_test.sv
module bmx_top_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tg_vld;
  logic [63:0]  tg_data;
  logic         tg_wide;
  logic [3:0]   tg_tag;
  logic         tg_rdy;
  logic [2:0]   dm_vld;
  logic [191:0] dm_data;
  logic [5:0]   dm_dwen;
  logic [2:0]   dm_demand;
  logic [2:0]   dm_eof;
  logic [2:0]   dm_rdy;
  logic [3:0]   tx_afull;
  logic [63:0]  tx_data;
  logic [3:0]   tx_type;
  logic [1:0]   tx_dwv;
  logic [4:0]   tx_info;
  logic         rx_vld;
  logic [3:0]   rx_type;
  logic [1:0]   rx_mark;
  logic [2:0]   rx_info;
  logic [63:0]  rx_data;
  logic [3:0]   ch_vld;
  logic [63:0]  ch_data;
  logic [1:0]   ch_mark;
  logic [2:0]   ch_info;
  logic         rx_bad_type;

  int check_n = 0;
  int fail_n  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmx_top uut (
    .clk(clk), .rst_n(rst_n),
    .tg_vld(tg_vld), .tg_data(tg_data), .tg_wide(tg_wide), .tg_tag(tg_tag), .tg_rdy(tg_rdy),
    .dm_vld(dm_vld), .dm_data(dm_data), .dm_dwen(dm_dwen), .dm_demand(dm_demand),
    .dm_eof(dm_eof), .dm_rdy(dm_rdy),
    .tx_afull(tx_afull), .tx_data(tx_data), .tx_type(tx_type), .tx_dwv(tx_dwv), .tx_info(tx_info),
    .rx_vld(rx_vld), .rx_type(rx_type), .rx_mark(rx_mark), .rx_info(rx_info), .rx_data(rx_data),
    .ch_vld(ch_vld), .ch_data(ch_data), .ch_mark(ch_mark), .ch_info(ch_info),
    .rx_bad_type(rx_bad_type)
  );

  task automatic expect_eq(input string rq, input logic [63:0] act, input logic [63:0] exp);
    check_n++;
    if (act !== exp) begin
      fail_n++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_inputs();
    tg_vld = 0; tg_data = '0; tg_wide = 0; tg_tag = '0;
    dm_vld = '0; dm_data = '0; dm_dwen = '0; dm_demand = '0; dm_eof = '0;
    tx_afull = '0;
    rx_vld = 0; rx_type = '0; rx_mark = '0; rx_info = '0; rx_data = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", check_n, fail_n);
  endtask

  // R1: outputs during and after reset
  task automatic test_reset();
    rst_n = 0;
    clear_inputs();
    repeat (3) @(posedge clk);
    #1;
    expect_eq("R1 reset tx_type", 64'(tx_type), 0);
    expect_eq("R1 reset tx_dwv", 64'(tx_dwv), 0);
    expect_eq("R1 reset ch_vld", 64'(ch_vld), 0);
    expect_eq("R1 reset bad flag", 64'(rx_bad_type), 0);
    @(negedge clk);
    rst_n = 1;
    tick();
    expect_eq("R1 idle after reset", 64'(tx_type), 0);
  endtask

  // R2: round-robin order with every channel requesting one-beat packets
  task automatic test_round_robin();
    tg_vld = 1; tg_data = 64'hAAAA;
    dm_vld = 3'b111; dm_eof = 3'b111; dm_dwen = 6'b111111;
    for (int i = 0; i < 6; i++) begin
      logic [3:0] exp_t;
      exp_t = 4'(1 << (i % 4));
      #1;
      expect_eq("R2 ready order", 64'({dm_rdy, tg_rdy}), 64'(exp_t));
      tick();
      expect_eq("R2 tx_type order", 64'(tx_type), 64'(exp_t));
    end
    clear_inputs();
    tick();
    expect_eq("R1 idle tx_type", 64'(tx_type), 0);
    expect_eq("R1 idle tx_dwv", 64'(tx_dwv), 0);
  endtask

  // R3: target packing
  task automatic test_target_info();
    tg_vld = 1; tg_wide = 0; tg_tag = 4'hA; tg_data = 64'h1234_5678_9ABC_DEF0;
    tick();
    expect_eq("R3 narrow type", 64'(tx_type), 64'h1);
    expect_eq("R3 narrow dwv", 64'(tx_dwv), 64'h1);
    expect_eq("R3 narrow info", 64'(tx_info), 64'h14);
    expect_eq("R3 narrow data", tx_data, 64'h1234_5678_9ABC_DEF0);
    tg_wide = 1; tg_tag = 4'h5;
    tick();
    expect_eq("R3 wide dwv", 64'(tx_dwv), 64'h3);
    expect_eq("R3 wide info", 64'(tx_info), 64'h0B);
    clear_inputs();
    tick();
  endtask

  // R4: DMA packing on engine 2
  task automatic test_dma_info();
    dm_vld[2] = 1; dm_dwen[5:4] = 2'b10; dm_demand[2] = 1; dm_eof[2] = 1;
    dm_data[128 +: 64] = 64'hCAFE_0002;
    tick();
    expect_eq("R4 dma type", 64'(tx_type), 64'h8);
    expect_eq("R4 dma dwv", 64'(tx_dwv), 64'h2);
    expect_eq("R4 dma info", 64'(tx_info), 64'h0E);
    expect_eq("R4 dma data", tx_data, 64'hCAFE_0002);
    clear_inputs();
    tick();
  endtask

  // R5: grant stays with a DMA engine until end of frame
  task automatic test_lock();
    dm_vld[0] = 1; dm_eof[0] = 0; dm_dwen[1:0] = 2'b11;
    tick();
    expect_eq("R5 first beat", 64'(tx_type), 64'h2);
    tg_vld = 1;
    #1;
    expect_eq("R5 target held off", 64'(tg_rdy), 0);
    tick();
    expect_eq("R5 second beat", 64'(tx_type), 64'h2);
    dm_eof[0] = 1;
    tick();
    expect_eq("R5 final beat", 64'(tx_type), 64'h2);
    dm_vld[0] = 0;
    tick();
    expect_eq("R5 target after release", 64'(tx_type), 64'h1);
    clear_inputs();
    tick();
  endtask

  // R6: almost-full channels are skipped
  task automatic test_afull_skip();
    dm_vld = 3'b011; dm_eof = 3'b011; dm_dwen = 6'b001111;
    tx_afull = 4'b0010;
    #1;
    expect_eq("R6 skip ready", 64'(dm_rdy), 64'h2);
    tick();
    expect_eq("R6 skip type", 64'(tx_type), 64'h4);
    tx_afull = 4'b0110;
    #1;
    expect_eq("R6 all blocked ready", 64'({dm_rdy, tg_rdy}), 0);
    tick();
    expect_eq("R6 all blocked type", 64'(tx_type), 0);
    clear_inputs();
    tick();
  endtask

  // R7: owner stalled by back-pressure mid-packet
  task automatic test_afull_stall();
    dm_vld[2] = 1; dm_eof[2] = 0; dm_dwen[5:4] = 2'b01;
    tick();
    expect_eq("R7 lock beat", 64'(tx_type), 64'h8);
    tx_afull = 4'b1000; tg_vld = 1;
    #1;
    expect_eq("R7 no ready while stalled", 64'({dm_rdy, tg_rdy}), 0);
    tick();
    expect_eq("R7 stalled type", 64'(tx_type), 0);
    expect_eq("R7 stalled dwv", 64'(tx_dwv), 0);
    tx_afull = '0; dm_eof[2] = 1;
    tick();
    expect_eq("R7 owner resumes", 64'(tx_type), 64'h8);
    dm_vld[2] = 0;
    tick();
    expect_eq("R7 target after packet", 64'(tx_type), 64'h1);
    clear_inputs();
    tick();
  endtask

  // R8: inbound routing to each channel
  task automatic test_route();
    for (int c = 0; c < 4; c++) begin
      rx_vld = 1; rx_type = 4'(1 << c); rx_mark = 2'(c);
      rx_info = 3'(c + 1); rx_data = 64'hF00 + 64'(c);
      tick();
      expect_eq("R8 ch_vld", 64'(ch_vld), 64'(1 << c));
      expect_eq("R8 ch_data", ch_data, 64'hF00 + 64'(c));
      expect_eq("R8 ch_mark", 64'(ch_mark), 64'(c));
      expect_eq("R8 ch_info", 64'(ch_info), 64'(c + 1));
    end
    rx_vld = 0;
    tick();
    expect_eq("R8 no beat", 64'(ch_vld), 0);
  endtask

  // R9: malformed inbound tag
  task automatic test_bad_type();
    expect_eq("R9 flag clear", 64'(rx_bad_type), 0);
    rx_vld = 1; rx_type = 4'b0011; rx_data = 64'hBAD;
    tick();
    expect_eq("R9 two-hot dropped", 64'(ch_vld), 0);
    expect_eq("R9 flag set", 64'(rx_bad_type), 1);
    rx_type = 4'b0000;
    tick();
    expect_eq("R9 zero tag dropped", 64'(ch_vld), 0);
    rx_type = 4'b0100; rx_data = 64'h600D;
    tick();
    expect_eq("R9 later beat routes", 64'(ch_vld), 64'h4);
    expect_eq("R9 flag sticky", 64'(rx_bad_type), 1);
    clear_inputs();
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      check_n++;
      fail_n++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    test_reset();
    test_round_robin();
    test_target_info();
    test_dma_info();
    test_lock();
    test_afull_skip();
    test_afull_stall();
    test_route();
    test_bad_type();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule